// File: doc/BRIEF.md
# Triggered Zero-Suppressed Frame Capture

This block sits behind one binary output chain of a pixel sensor that streams its frame without pause. Every clock cycle carries one pixel value, and a marker pulse flags the first pixel of each frame. The block keeps a row and column position counter in step with the stream. The marker forces that counter back to the origin, so a counter that has slipped is corrected at the next frame.

A trigger pulse arms the block, and capture begins at the next frame marker and covers that whole frame. For each pixel whose value is 1, the block stores one address word in a rotating event buffer. After the last pixel of the frame it closes the event. An event builder reads the finished events in order through a show-ahead port. Each event is its hit words followed by a trailer word that gives the stored hit count and an overflow flag.

The block accepts triggers with no dead time as long as a buffer is still free. When every buffer is taken, it raises busy and counts each further trigger as dropped.

Top module: `hit_frame_capture`

## Requirements
- R1: After reset, rd_valid is 0, busy is 0 and drop_cnt is 0.
- R2: Only pixels with value 1 in a captured frame produce a hit word. A hit word has bit 20 clear, the row in bits 19:10 and the column in bits 9:0. The column is CHAIN_ID*CHAIN_COLS plus the position within the chain. The column advances fastest, and the marker cycle carries row 0, chain position 0.
- R3: A trigger accepted during a frame starts capture at the next frame marker. A trigger in the same cycle as a marker does not capture the frame that marker opens; it captures the following frame.
- R4: One accepted trigger captures exactly one frame. Further triggers that arrive before the armed capture starts merge into it and add no event.
- R5: After its hit words, each event ends with a trailer word. The trailer has bit 20 set, the overflow flag in bit 19, zeros below that, and the number of stored hit words in the low bits.
- R6: Hits beyond DEPTH in one frame are not stored. The trailer count then stays at DEPTH and its overflow flag is 1.
- R7: busy is 1 while completed, capturing and armed events together fill all NBUF buffers. A trigger while busy adds 1 to drop_cnt and changes no event, and a trigger while not busy leaves drop_cnt unchanged.
- R8: Events are read in capture order. rd_valid and rd_data hold until rd_en pops the word. Popping a trailer frees that buffer, which clears busy.
- R9: A marker in the middle of a frame restarts the position at row 0, chain position 0. It also closes any capture in progress as a shortened event that holds the hits seen up to that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 1 | Binary pixel value from the chain |
| frame_mark | input | 1 | High on the first pixel of a frame |
| trig | input | 1 | Trigger pulse |
| busy | output | 1 | No free event buffer |
| drop_cnt | output | DROP_W | Triggers refused while busy |
| rd_en | input | 1 | Pop the presented word |
| rd_valid | output | 1 | A completed event is presented |
| rd_data | output | ROW_W+COL_W+1 | Hit word or trailer word |

## Verification
A trigger and a frame marker can arrive in the same cycle. The design must then leave the opening frame out and arm for the one after it. The bench pulses the trigger exactly on a marker pixel, with hits in that frame and different hits in the next one. It then judges by reading out a single event that holds only the second frame's addresses, followed by an empty port. A second overlap is a marker that ends one capture and starts another in the same cycle. The bench provokes it with a shortened frame that carries a new trigger, and it checks both resulting events word by word.

// File: rtl/hit_frame_capture.sv
module hit_frame_capture #(
  parameter int ROWS       = 640,
  parameter int CHAIN_COLS = 160,
  parameter int CHAIN_ID   = 0,
  parameter int ROW_W      = 10,
  parameter int COL_W      = 10,
  parameter int NBUF       = 2,
  parameter int DEPTH      = 16,
  parameter int DROP_W     = 16,
  localparam int ADDR_W    = ROW_W + COL_W,
  localparam int WORD_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_in,
  input  logic              frame_mark,
  input  logic              trig,
  output logic              busy,
  output logic [DROP_W-1:0] drop_cnt,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  localparam int BUF_W = $clog2(NBUF);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PAD_W = ADDR_W - 1 - CNT_W;

  function automatic logic [BUF_W-1:0] nxt(input logic [BUF_W-1:0] p);
    return (p == BUF_W'(NBUF - 1)) ? '0 : p + BUF_W'(1);
  endfunction

  logic [ROW_W-1:0] row_q, row_c;
  logic [COL_W-1:0] lcol_q, lcol_c;
  logic             last_pix;
  logic [ADDR_W-1:0] addr;

  assign row_c    = frame_mark ? '0 : row_q;
  assign lcol_c   = frame_mark ? '0 : lcol_q;
  assign last_pix = (row_c == ROW_W'(ROWS - 1)) && (lcol_c == COL_W'(CHAIN_COLS - 1));
  assign addr     = {row_c, COL_W'(CHAIN_ID * CHAIN_COLS) + lcol_c};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '0;
      lcol_q <= '0;
    end else if (lcol_c == COL_W'(CHAIN_COLS - 1)) begin
      lcol_q <= '0;
      row_q  <= (row_c == ROW_W'(ROWS - 1)) ? '0 : row_c + ROW_W'(1);
    end else begin
      lcol_q <= lcol_c + COL_W'(1);
      row_q  <= row_c;
    end
  end

  logic             pend, cap, ovf_q;
  logic [BUF_W-1:0] wr_buf, rd_buf, wb;
  logic [BUF_W:0]   n_done;
  logic [CNT_W-1:0] hcnt, base, hcnt_n, rd_idx;
  logic [DROP_W-1:0] drop_q;
  logic [BUF_W+1:0] occ;
  logic accept, start, abort, act, fresh, hit, store, close, ovf_n, pop, at_tr;

  logic [ADDR_W-1:0] mem  [NBUF][DEPTH];
  logic [CNT_W-1:0]  tcnt [NBUF];
  logic              tovf [NBUF];

  assign occ    = (BUF_W+2)'(n_done) + (BUF_W+2)'(cap) + (BUF_W+2)'(pend);
  assign busy   = occ >= (BUF_W+2)'(NBUF);
  assign accept = trig & ~busy;
  assign start  = frame_mark & pend;
  assign abort  = frame_mark & cap;
  assign act    = (cap & ~frame_mark) | start;
  assign wb     = abort ? nxt(wr_buf) : wr_buf;
  assign fresh  = start | abort;
  assign base   = fresh ? '0 : hcnt;
  assign hit    = act & pix_in;
  assign store  = hit & (base < CNT_W'(DEPTH));
  assign hcnt_n = store ? base + CNT_W'(1) : base;
  assign ovf_n  = (~fresh & ovf_q) | (hit & ~store);
  assign close  = act & last_pix;

  assign rd_valid = (n_done != '0);
  assign at_tr    = (rd_idx == tcnt[rd_buf]);
  assign pop      = rd_en & rd_valid;
  assign drop_cnt = drop_q;
  assign rd_data  = at_tr ? {1'b1, tovf[rd_buf], {PAD_W{1'b0}}, tcnt[rd_buf]}
                          : {1'b0, mem[rd_buf][rd_idx[IDX_W-1:0]]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      cap    <= 1'b0;
      ovf_q  <= 1'b0;
      hcnt   <= '0;
      wr_buf <= '0;
      rd_buf <= '0;
      rd_idx <= '0;
      n_done <= '0;
      drop_q <= '0;
    end else begin
      pend   <= (pend & ~start) | accept;
      cap    <= act & ~last_pix;
      hcnt   <= hcnt_n;
      ovf_q  <= ovf_n;
      wr_buf <= close ? nxt(wb) : wb;
      n_done <= n_done + (BUF_W+1)'(abort) + (BUF_W+1)'(close) - (BUF_W+1)'(pop & at_tr);
      drop_q <= drop_q + DROP_W'(trig & busy);
      if (pop) begin
        rd_idx <= at_tr ? '0 : rd_idx + CNT_W'(1);
        if (at_tr) rd_buf <= nxt(rd_buf);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[wb][base[IDX_W-1:0]] <= addr;
    if (abort) begin
      tcnt[wr_buf] <= hcnt;
      tovf[wr_buf] <= ovf_q;
    end
    if (close) begin
      tcnt[wb] <= hcnt_n;
      tovf[wb] <= ovf_n;
    end
  end
endmodule

// File: rtl/hit_frame_capture_chk.sv
module hit_frame_capture_chk #(
  parameter int DROP_W = 16,
  parameter int WORD_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              busy,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [DROP_W-1:0] drop_cnt,
  input logic [WORD_W-1:0] rd_data
);
  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy) |=> drop_cnt == $past(drop_cnt));

  // R7
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> drop_cnt == $past(drop_cnt) + DROP_W'(1));

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |=> rd_valid);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |=> $stable(rd_data));
endmodule

bind hit_frame_capture hit_frame_capture_chk #(.DROP_W(DROP_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .rd_en(rd_en),
  .rd_valid(rd_valid), .drop_cnt(drop_cnt), .rd_data(rd_data));

// File: tb/tb_hit_frame_capture.sv
`timescale 1ns/1ps
module tb_hit_frame_capture;
  localparam int T_ROWS = 3, T_CC = 4, T_ID = 2, T_NBUF = 2, T_DEPTH = 4, T_PIX = 12;

  logic clk = 1'b0, rst_n = 1'b0, pix_in = 1'b0, frame_mark = 1'b0, trig = 1'b0, rd_en = 1'b0;
  logic busy, rd_valid;
  logic [15:0] drop_cnt;
  logic [20:0] rd_data;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  hit_frame_capture #(.ROWS(T_ROWS), .CHAIN_COLS(T_CC), .CHAIN_ID(T_ID),
                      .NBUF(T_NBUF), .DEPTH(T_DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .frame_mark(frame_mark), .trig(trig),
    .busy(busy), .drop_cnt(drop_cnt), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data));

  // {pattern, expected stored count, expected overflow}
  localparam logic [16:0] VEC [0:6] = '{
    {12'h000, 4'd0, 1'b0}, {12'h001, 4'd1, 1'b0}, {12'h800, 4'd1, 1'b0},
    {12'h0F0, 4'd4, 1'b0}, {12'h1F0, 4'd4, 1'b1}, {12'hFFF, 4'd4, 1'b1},
    {12'h421, 4'd3, 1'b0}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] hit_word(input int i);
    return {1'b0, 10'(i / T_CC), 10'(T_ID * T_CC + i % T_CC)};
  endfunction

  task automatic run_frame(input logic [11:0] pat, input int npix, input logic [11:0] tmask);
    for (int i = 0; i < npix; i++) begin
      @(negedge clk);
      frame_mark = (i == 0);
      pix_in = pat[i];
      trig = tmask[i];
    end
    @(negedge clk);
    frame_mark = 1'b0; pix_in = 1'b0; trig = 1'b0;
  endtask

  task automatic pop_word();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_event(input logic [11:0] pat, input int npix, input int ecnt,
                            input bit eovf, input string req);
    int n = 0;
    @(negedge clk);
    chk(rd_valid == 1'b1, req, 32'(rd_valid), 32'd1);
    for (int i = 0; i < npix; i++) begin
      if (pat[i] && n < T_DEPTH) begin
        chk(rd_data == hit_word(i), "R2 hit word", 32'(rd_data), 32'(hit_word(i)));
        pop_word();
        n++;
      end
    end
    chk(rd_data == {1'b1, eovf, 16'b0, 3'(ecnt)}, req, 32'(rd_data),
        32'({1'b1, eovf, 16'b0, 3'(ecnt)}));
    pop_word();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(drop_cnt == 16'd0, "R1 drop_cnt", 32'(drop_cnt), 0);

    // R2 R5 R6: table of frame patterns, each armed by a trigger in the frame before
    for (int v = 0; v < 7; v++) begin
      run_frame(12'h000, T_PIX, 12'h020);
      run_frame(VEC[v][16:5], T_PIX, 12'h000);
      read_event(VEC[v][16:5], T_PIX, int'(VEC[v][4:1]), VEC[v][0],
                 VEC[v][0] ? "R6 overflow trailer" : "R5 trailer");
      chk(rd_valid == 1'b0, "R5 one event per trigger", 32'(rd_valid), 0);
    end

    // R3: trigger coinciding with a marker skips that frame
    run_frame(12'h00F, T_PIX, 12'h001);
    run_frame(12'h840, T_PIX, 12'h000);
    read_event(12'h840, T_PIX, 2, 1'b0, "R3 next frame captured");
    chk(rd_valid == 1'b0, "R3 marker frame not captured", 32'(rd_valid), 0);

    // R4: two triggers in one frame merge into one capture
    d0 = drop_cnt;
    run_frame(12'h000, T_PIX, 12'h042);
    run_frame(12'h014, T_PIX, 12'h000);
    run_frame(12'h0FF, T_PIX, 12'h000);
    chk(busy == 1'b0, "R4 busy after merged capture", 32'(busy), 0);
    read_event(12'h014, T_PIX, 2, 1'b0, "R4 merged event");
    chk(rd_valid == 1'b0, "R4 no second event", 32'(rd_valid), 0);
    chk(drop_cnt == d0, "R4 no drop on merge", 32'(drop_cnt), 32'(d0));

    // R7 R8: fill both buffers, refuse further triggers
    d0 = drop_cnt;
    run_frame(12'h000, T_PIX, 12'h008);
    run_frame(12'h081, T_PIX, 12'h084);
    run_frame(12'h300, T_PIX, 12'h000);
    chk(busy == 1'b1, "R7 busy when full", 32'(busy), 1);
    run_frame(12'hFFF, T_PIX, 12'h020);
    chk(busy == 1'b1, "R7 still busy", 32'(busy), 1);
    chk(drop_cnt == d0 + 16'd2, "R7 dropped triggers", 32'(drop_cnt), 32'(d0 + 16'd2));
    read_event(12'h081, T_PIX, 2, 1'b0, "R8 first event in order");
    chk(busy == 1'b0, "R8 buffer freed after trailer", 32'(busy), 0);
    read_event(12'h300, T_PIX, 2, 1'b0, "R8 second event in order");
    chk(rd_valid == 1'b0, "R7 dropped trigger adds no event", 32'(rd_valid), 0);

    // R9: early marker closes a shortened event and resynchronises the position
    run_frame(12'h000, T_PIX, 12'h008);
    run_frame(12'hF22, 6, 12'h002);
    run_frame(12'h210, T_PIX, 12'h000);
    read_event(12'hF22, 6, 2, 1'b0, "R9 shortened event");
    read_event(12'h210, T_PIX, 2, 1'b0, "R9 resynchronised frame");
    chk(rd_valid == 1'b0, "R9 no extra event", 32'(rd_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule